// File: doc/BRIEF.md
# Adjacent-error memory ECC codec

This block protects one 40-bit memory word that holds 32 data bits and 8 check bits. The write side is a combinational encoder: it turns a 32-bit data value into the 40-bit word to be stored. The read side decodes a stored word in one registered stage. It repairs any one flipped bit and any two flipped bits that sit next to each other. When three neighbouring bits are flipped, it reports the word as uncorrectable and does not try to repair it. Two saturating event counters record how many reads were repaired and how many were uncorrectable. A register interface reads the counters and clears them.

The code uses a fixed parity-check matrix. The stored bit order 0..39 mixes check bits and data bits, so "adjacent" means adjacent in that stored order. Each syndrome has two parts. A 3-bit class tag tells apart a one-bit error, a two-bit error and a three-bit error. A 5-bit value then picks out the position inside the class.

Read results leave through a valid/ready stage. A read is accepted when `rd_valid` and `rd_ready` are both high. `rd_ready` is high whenever the output register is empty or is being emptied in the same cycle. While `res_valid` is high and `res_ready` is low, the output holds still and no new read is taken.

Top module: `adj_ecc_codec`

## Requirements
- R1: Syndrome column for stored bit i (k = i/3, rounded down) is {k, 3'b001} when i%3==0, {k^(k<<1), 3'b010} when i%3==1, and {k<<1, 3'b100} when i%3==2. The 5-bit value is in syndrome bits [7:3] and the tag is in bits [2:0]. Check bits sit at stored positions 0,1,2,3,6,12,24,26. Data bit 0..31 fills the other positions in ascending order. The encoder output always has a zero syndrome.
- R2: A read of an error-free word returns its data with both flags low.
- R3: Any single flipped bit among the 40 is repaired and raises only `res_corrected`.
- R4: Any two flipped neighbouring bits (i, i+1) are repaired and raise only `res_corrected`.
- R5: Any three flipped neighbouring bits raise only `res_uncorr`. The data bits are then passed on unmodified from the word as read.
- R6: A read accepted at one clock edge shows up with `res_valid` high right after the next edge: one cycle of latency.
- R7: While `res_valid` is high and `res_ready` is low, `rd_ready` is low, and `res_data` and both flags hold still. An offered read is not taken.
- R8: Each accepted repaired read adds one to `cnt_corr` only. Each accepted uncorrectable read adds one to `cnt_uncorr` only.
- R9: Both counters stop at all ones and never wrap.
- R10: `cnt_clr` zeroes both counters at the next edge and overrides an event in the same cycle.
- R11: After reset, `res_valid` is low, `rd_ready` is high and both counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_data | input | 32 | Data to encode |
| wr_word | output | 40 | Encoded word to store |
| rd_valid | input | 1 | Read word offered |
| rd_ready | output | 1 | Read word can be taken |
| rd_word | input | 40 | Stored word as read from memory |
| res_valid | output | 1 | Decoded result present |
| res_ready | input | 1 | Consumer takes the result |
| res_data | output | 32 | Repaired data |
| res_corrected | output | 1 | Result was repaired |
| res_uncorr | output | 1 | Result is uncorrectable |
| cnt_clr | input | 1 | Synchronous clear of both counters |
| cnt_corr | output | CNT_W | Repaired-read counter |
| cnt_uncorr | output | CNT_W | Uncorrectable-read counter |

## Verification
The bench builds the block with CNT_W = 4, so each counter saturates at 15. With that width, the 40 single-bit reads and 38 triple-bit reads in one scenario drive the counters past the stopping point. The same runs also exercise each error class exhaustively. The code matrix is the same at any counter width, so every position of every error class is reached with this setting.

// File: rtl/adj_ecc_pkg.sv
package adj_ecc_pkg;
  localparam int WORD_W = 40;
  localparam int DATA_W = 32;
  localparam int CHK_W  = 8;
  localparam int TAG_W  = 3;

  // syndrome column for stored position i: value in [7:3], class tag in [2:0]
  function automatic logic [CHK_W-1:0] h_col(input int i);
    logic [4:0] k;
    k = 5'(i / 3);
    case (i % 3)
      0:       return {k, 3'b001};
      1:       return {k ^ (k << 1), 3'b010};
      default: return {k << 1, 3'b100};
    endcase
  endfunction

  function automatic bit is_chk(input int i);
    return (i == 0) || (i == 1) || (i == 2) || (i == 3) ||
           (i == 6) || (i == 12) || (i == 24) || (i == 26);
  endfunction

  // stored position of data bit j
  function automatic int data_pos(input int j);
    int n;
    n = 0;
    for (int i = 0; i < WORD_W; i++) begin
      if (!is_chk(i)) begin
        if (n == j) return i;
        n++;
      end
    end
    return 0;
  endfunction

  function automatic logic [CHK_W-1:0] syndrome(input logic [WORD_W-1:0] w);
    logic [CHK_W-1:0] s;
    s = '0;
    for (int i = 0; i < WORD_W; i++)
      if (w[i]) s ^= h_col(i);
    return s;
  endfunction
endpackage

// File: rtl/adj_ecc_encoder.sv
module adj_ecc_encoder
  import adj_ecc_pkg::*;
(
  input  logic [DATA_W-1:0] data,
  output logic [WORD_W-1:0] word
);
  logic [WORD_W-1:0] spread;
  logic [CHK_W-1:0]  s;
  logic [TAG_W-1:0]  t;

  always_comb begin
    spread = '0;
    for (int j = 0; j < DATA_W; j++) spread[data_pos(j)] = data[j];
    s = syndrome(spread);
    // positions 3,6,12,24 cancel value bits 0..3 (tag 001); 26 cancels bit 4 (tag 100)
    t = s[2:0] ^ {s[7], 1'b0, s[3] ^ s[4] ^ s[5] ^ s[6]};
    word      = spread;
    word[3]   = s[3];
    word[6]   = s[4];
    word[12]  = s[5];
    word[24]  = s[6];
    word[26]  = s[7];
    word[0]   = t[0];
    word[1]   = t[1];
    word[2]   = t[2];
  end

  // R1: stored word must check clean
  always_comb begin
    a_r1_clean_syndrome: assert (syndrome(word) == '0)
      else $error("encoder produced nonzero syndrome");
  end
endmodule

// File: rtl/adj_ecc_decoder.sv
module adj_ecc_decoder
  import adj_ecc_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output logic [WORD_W-1:0] flip,
  output logic              corr,
  output logic              uncorr
);
  logic [CHK_W-1:0]  syn;
  logic [WORD_W-1:0] one_hit;
  logic [WORD_W-2:0] two_hit;

  assign syn = syndrome(word);

  for (genvar i = 0; i < WORD_W; i++) begin : g_one
    assign one_hit[i] = (syn == h_col(i));
  end

  for (genvar i = 0; i < WORD_W - 1; i++) begin : g_two
    assign two_hit[i] = (syn == (h_col(i) ^ h_col(i + 1)));
  end

  for (genvar i = 0; i < WORD_W; i++) begin : g_mask
    if (i == 0) begin : g_lo
      assign flip[i] = one_hit[i] | two_hit[i];
    end else if (i == WORD_W - 1) begin : g_hi
      assign flip[i] = one_hit[i] | two_hit[i-1];
    end else begin : g_mid
      assign flip[i] = one_hit[i] | two_hit[i-1] | two_hit[i];
    end
  end

  assign corr   = (syn != '0) &&  (|{one_hit, two_hit});
  assign uncorr = (syn != '0) && !(|{one_hit, two_hit});
endmodule

// File: rtl/adj_ecc_sat_counter.sv
module adj_ecc_sat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n)                    count <= '0;
    else if (clr)                  count <= '0;
    else if (inc && count != '1)   count <= count + 1'b1;
  end

  a_r9_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '1 && !clr) |=> count == '1);
  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> count == '0);
  a_r8_step: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (count == $past(count)) || (count == $past(count) + 1'b1));
endmodule

// File: rtl/adj_ecc_codec.sv
module adj_ecc_codec
  import adj_ecc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] wr_data,
  output logic [WORD_W-1:0] wr_word,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [WORD_W-1:0] rd_word,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [DATA_W-1:0] res_data,
  output logic              res_corrected,
  output logic              res_uncorr,
  input  logic              cnt_clr,
  output logic [CNT_W-1:0]  cnt_corr,
  output logic [CNT_W-1:0]  cnt_uncorr
);
  logic [WORD_W-1:0] flip, fixed;
  logic [DATA_W-1:0] data_nx;
  logic              corr, uncorr, take;

  adj_ecc_encoder u_enc (.data(wr_data), .word(wr_word));
  adj_ecc_decoder u_dec (.word(rd_word), .flip(flip), .corr(corr), .uncorr(uncorr));

  assign fixed = rd_word ^ flip;
  for (genvar j = 0; j < DATA_W; j++) begin : g_ext
    assign data_nx[j] = fixed[data_pos(j)];
  end

  assign rd_ready = !res_valid || res_ready;
  assign take     = rd_valid && rd_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid     <= 1'b0;
      res_data      <= '0;
      res_corrected <= 1'b0;
      res_uncorr    <= 1'b0;
    end else begin
      if (rd_ready) res_valid <= rd_valid;
      if (take) begin
        res_data      <= data_nx;
        res_corrected <= corr;
        res_uncorr    <= uncorr;
      end
    end
  end

  adj_ecc_sat_counter #(.W(CNT_W)) u_cnt_corr (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(take && corr), .count(cnt_corr));
  adj_ecc_sat_counter #(.W(CNT_W)) u_cnt_uncorr (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(take && uncorr), .count(cnt_uncorr));

  a_r6_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready) |=> res_valid);
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> res_valid && $stable(res_data) &&
      $stable(res_corrected) && $stable(res_uncorr));
  a_r5_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !(res_corrected && res_uncorr));
  a_r8_single_counter: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_clr |=> !((cnt_corr != $past(cnt_corr)) && (cnt_uncorr != $past(cnt_uncorr))));
endmodule

// File: tb/adj_ecc_codec_test.sv
module adj_ecc_codec_test;
  localparam int CW = 4;
  localparam int MAXC = (1 << CW) - 1;

  logic clk = 0, rst_n = 0;
  logic [31:0] wr_data = '0;
  logic [39:0] wr_word, rd_word = '0;
  logic rd_valid = 0, rd_ready, res_valid, res_ready = 1;
  logic [31:0] res_data;
  logic res_corrected, res_uncorr, cnt_clr = 0;
  logic [CW-1:0] cnt_corr, cnt_uncorr;
  int total = 0, bad = 0, exp_c = 0, exp_u = 0;
  bit done = 0;
  int cpos [8] = '{0, 1, 2, 3, 6, 12, 24, 26};

  always #2.5 clk = ~clk;

  adj_ecc_codec #(.CNT_W(CW)) uut (.*);

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] b_col(input int i);
    logic [4:0] k = 5'(i / 3);
    if (i % 3 == 0) return {k, 3'b001};
    if (i % 3 == 1) return {k ^ (k << 1), 3'b010};
    return {k << 1, 3'b100};
  endfunction

  function automatic logic [7:0] b_syn(input logic [39:0] w);
    logic [7:0] s = '0;
    for (int i = 0; i < 40; i++) if (w[i]) s ^= b_col(i);
    return s;
  endfunction

  function automatic bit b_ischk(input int i);
    for (int c = 0; c < 8; c++) if (cpos[c] == i) return 1;
    return 0;
  endfunction

  function automatic logic [39:0] b_encode(input logic [31:0] d);
    logic [39:0] w = '0;
    int n = 0;
    for (int i = 0; i < 40; i++) if (!b_ischk(i)) begin w[i] = d[n]; n++; end
    for (int c = 0; c < 256; c++) begin
      for (int b = 0; b < 8; b++) w[cpos[b]] = c[b];
      if (b_syn(w) == 8'h00) return w;
    end
    return '0;
  endfunction

  function automatic logic [31:0] b_extract(input logic [39:0] w);
    logic [31:0] d = '0;
    int n = 0;
    for (int i = 0; i < 40; i++) if (!b_ischk(i)) begin d[n] = w[i]; n++; end
    return d;
  endfunction

  function automatic int sat(input int v);
    return (v > MAXC) ? MAXC : v;
  endfunction

  task automatic clear_counters();
    @(negedge clk); cnt_clr = 1;
    @(negedge clk); cnt_clr = 0;
    exp_c = 0; exp_u = 0;
  endtask

  task automatic do_read(input logic [39:0] w, input logic [31:0] ed, input bit ec, input bit eu, input string req);
    @(negedge clk); rd_word = w; rd_valid = 1; res_ready = 1;
    @(negedge clk); rd_valid = 0;
    if (ec) exp_c = sat(exp_c + 1);
    if (eu) exp_u = sat(exp_u + 1);
    chk(req, "res_valid", 64'(res_valid), 64'd1);
    chk(req, "res_data", 64'(res_data), 64'(ed));
    chk(req, "corrected", 64'(res_corrected), 64'(ec));
    chk(req, "uncorr", 64'(res_uncorr), 64'(eu));
    chk(req, "cnt_corr", 64'(cnt_corr), 64'(exp_c));
    chk(req, "cnt_uncorr", 64'(cnt_uncorr), 64'(exp_u));
  endtask

  task automatic t_reset();
    chk("R11", "res_valid", 64'(res_valid), 64'd0);
    chk("R11", "rd_ready", 64'(rd_ready), 64'd1);
    chk("R11", "cnt_corr", 64'(cnt_corr), 64'd0);
    chk("R11", "cnt_uncorr", 64'(cnt_uncorr), 64'd0);
  endtask

  task automatic t_encode();
    logic [31:0] pats [4] = '{32'h0, 32'hFFFF_FFFF, 32'hA5A5_5A5A, $urandom};
    for (int p = 0; p < 4; p++) begin
      @(negedge clk); wr_data = pats[p];
      #1 chk("R1", "wr_word", 64'(wr_word), 64'(b_encode(pats[p])));
    end
  endtask

  task automatic t_clean();
    clear_counters();
    for (int p = 0; p < 6; p++) begin
      logic [31:0] d = (p == 0) ? 32'h0 : (p == 1) ? 32'hFFFF_FFFF : $urandom;
      do_read(b_encode(d), d, 0, 0, "R2");
    end
  endtask

  task automatic t_single();
    clear_counters();
    for (int i = 0; i < 40; i++) begin
      logic [31:0] d = $urandom;
      do_read(b_encode(d) ^ (40'd1 << i), d, 1, 0, "R3");
    end
    chk("R9", "cnt_corr saturated", 64'(cnt_corr), 64'(MAXC));
  endtask

  task automatic t_pair();
    clear_counters();
    for (int i = 0; i < 39; i++) begin
      logic [31:0] d = $urandom;
      do_read(b_encode(d) ^ (40'd3 << i), d, 1, 0, "R4");
    end
  endtask

  task automatic t_triple();
    clear_counters();
    for (int i = 0; i < 38; i++) begin
      logic [31:0] d = $urandom;
      logic [39:0] w = b_encode(d) ^ (40'd7 << i);
      do_read(w, b_extract(w), 0, 1, "R5");
    end
    chk("R8", "cnt_corr untouched by uncorrectable", 64'(cnt_corr), 64'd0);
    chk("R9", "cnt_uncorr saturated", 64'(cnt_uncorr), 64'(MAXC));
  endtask

  task automatic t_stall();
    logic [31:0] d1 = $urandom, d2 = $urandom;
    clear_counters();
    @(negedge clk); rd_word = b_encode(d1); rd_valid = 1; res_ready = 0;
    @(negedge clk); rd_word = b_encode(d2) ^ 40'd16;
    chk("R6", "res_valid after one cycle", 64'(res_valid), 64'd1);
    chk("R7", "rd_ready while stalled", 64'(rd_ready), 64'd0);
    @(negedge clk);
    chk("R7", "res_valid held", 64'(res_valid), 64'd1);
    chk("R7", "res_data held", 64'(res_data), 64'(d1));
    chk("R7", "offered read not counted", 64'(cnt_corr), 64'd0);
    rd_valid = 0; res_ready = 1;
    @(negedge clk);
    chk("R7", "res_valid drained", 64'(res_valid), 64'd0);
    chk("R7", "cnt_corr after drain", 64'(cnt_corr), 64'd0);
  endtask

  task automatic t_clear_priority();
    logic [31:0] d = $urandom;
    clear_counters();
    do_read(b_encode(d) ^ 40'd2, d, 1, 0, "R8");
    @(negedge clk); rd_word = b_encode(d) ^ 40'd4; rd_valid = 1; cnt_clr = 1;
    @(negedge clk); rd_valid = 0; cnt_clr = 0;
    chk("R10", "cnt_corr cleared over event", 64'(cnt_corr), 64'd0);
    chk("R10", "event still delivered", 64'(res_corrected), 64'd1);
    @(negedge clk);
    chk("R10", "cnt_corr stays zero", 64'(cnt_corr), 64'd0);
    exp_c = 0; exp_u = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_encode();
    t_clean();
    t_single();
    t_pair();
    t_triple();
    t_stall();
    t_clear_priority();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end
endmodule